// File: doc/BRIEF.md
# Dual Spatial Pattern Learner

This block keeps a small direct-indexed table of trained signature entries. Each entry holds two spatial bit-patterns over the cache lines of one page. One pattern leans towards coverage and the other towards accuracy. Each entry also holds three 2-bit saturating counters. Bit i of every pattern stands for the line at delta i from the first access that opened the page. Patterns therefore describe lines relative to that trigger and not by absolute offset.

When a page finishes, the surrounding logic presents the page's anchored access pattern together with the index of its table entry, in a single-cycle update. The learner scores the stored patterns against the incoming one. It counts the matching bits and buckets the coverage and accuracy ratios into quartiles. It then steps the confidence counters and merges the incoming pattern into both stored patterns. A combinational read port returns one entry's patterns and counters for the prediction logic.

Top module: `dual_pattern_learner`

## Requirements
- R1: After reset every entry reads back untrained (rd_valid 0), with both patterns zero and all three counters zero.
- R2: An update to an untrained entry marks it trained, sets both patterns to the incoming pattern and clears all three counters.
- R3: An update to a trained entry sets the accuracy pattern to the bitwise AND of the incoming pattern and the coverage pattern held before the update.
- R4: An update to a trained entry whose merge counter is below 3 sets the coverage pattern to the OR of the old coverage pattern and the incoming pattern, and adds one to the merge counter.
- R5: An update to a trained entry whose merge counter equals 3 replaces the coverage pattern with the incoming pattern and clears the merge counter.
- R6: A ratio m/d maps to bucket 3 when 4m >= 3d, else 2 when 4m >= 2d, else 1 when 4m >= d, else 0. A zero denominator gives bucket 0. Here "match" means bits set in both the incoming pattern and the stored pattern.
- R7: The coverage-pattern confidence counter (rd_meas_cov) is updated from two buckets. Coverage is matches over the incoming pattern's popcount, and accuracy is matches over the old coverage pattern's popcount. The counter goes up by one, saturating at 3, when either bucket is below 2. Otherwise it goes down by one, saturating at 0.
- R8: The accuracy-pattern confidence counter (rd_meas_acc) is updated from the accuracy bucket, which is matches with the old accuracy pattern over that pattern's popcount. The counter goes up by one, saturating at 3, when the bucket is below 2. Otherwise it goes down by one, saturating at 0.
- R9: A cycle with upd_valid low changes no entry, and an update changes only the indexed entry.
- R10: The read port shows an update's result from the clock edge that registers it, following rd_index combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Presents one finished page pattern this cycle |
| upd_index | input | IDX_W (4) | Table entry to train |
| upd_pattern | input | LINES (64) | Anchored access pattern of the finished page |
| rd_index | input | IDX_W (4) | Entry shown on the read port |
| rd_valid | output | 1 | Entry has been trained |
| rd_cov_pat | output | LINES (64) | Coverage-leaning pattern |
| rd_acc_pat | output | LINES (64) | Accuracy-leaning pattern |
| rd_or_count | output | 2 | Number of OR merges since the last replacement |
| rd_meas_cov | output | 2 | Confidence counter of the coverage pattern |
| rd_meas_acc | output | 2 | Confidence counter of the accuracy pattern |

## Verification
The assertions take for granted that upd_index is always inside the table and that the matching-bit count never exceeds the denominator it is scored against. Both hold by construction of the inputs, because a match is always a subset of both operands. The read-port property assumes rd_index is held across the update edge, so the bench changes rd_index and the update inputs only at falling edges. The stimulus walks one entry through every counter state, including saturation at both ends and exact 25% and 50% ratios. It also includes empty patterns and bit 63, so each quartile boundary and the empty-denominator case is reached.

// File: rtl/dspl_pkg.sv
package dspl_pkg;

    localparam int CNT_W = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        QB_LOW  = 2'd0,
        QB_QTR  = 2'd1,
        QB_HALF = 2'd2,
        QB_HIGH = 2'd3
    } qbucket_e;

endpackage

// File: rtl/dspl_popcount.sv
module dspl_popcount #(
    parameter int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/dspl_quartile.sv
module dspl_quartile
    import dspl_pkg::*;
#(
    parameter int CW = 7,
    localparam int XW = CW + 2
) (
    input  logic [CW-1:0] hits,
    input  logic [CW-1:0] total,
    output qbucket_e      bucket
);
    logic [XW-1:0] hits_x4;
    logic [XW-1:0] total_x1;
    logic [XW-1:0] total_x2;
    logic [XW-1:0] total_x3;

    always_comb begin
        hits_x4  = {hits, 2'b00};
        total_x1 = XW'(total);
        total_x2 = XW'(total) << 1;
        total_x3 = total_x2 + total_x1;
        if (total == '0)               bucket = QB_LOW;
        else if (hits_x4 >= total_x3)  bucket = QB_HIGH;
        else if (hits_x4 >= total_x2)  bucket = QB_HALF;
        else if (hits_x4 >= total_x1)  bucket = QB_QTR;
        else                           bucket = QB_LOW;
    end

    // R6: a match count can never exceed its denominator
    always_comb begin
        a_r6_hits_bounded: assert (!(hits > total))
            else $error("quartile: hits above total");
    end
endmodule

// File: rtl/dspl_sat_counter.sv
module dspl_sat_counter #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] cur,
    input  logic          up,
    output logic [CW-1:0] nxt
);
    localparam logic [CW-1:0] TOP = '1;

    always_comb begin
        if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
        else    nxt = (cur == '0)  ? cur : cur - 1'b1;
    end
endmodule

// File: rtl/dual_pattern_learner.sv
module dual_pattern_learner
    import dspl_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PC_W   = $clog2(LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic [LINES-1:0] upd_pattern,
    input  logic [IDX_W-1:0] rd_index,
    output logic             rd_valid,
    output logic [LINES-1:0] rd_cov_pat,
    output logic [LINES-1:0] rd_acc_pat,
    output logic [CNT_W-1:0] rd_or_count,
    output logic [CNT_W-1:0] rd_meas_cov,
    output logic [CNT_W-1:0] rd_meas_acc
);
    localparam cnt_t CNT_TOP = '1;

    typedef struct packed {
        logic             trained;
        logic [LINES-1:0] cov;
        logic [LINES-1:0] acc;
        cnt_t             merges;
        cnt_t             conf_cov;
        cnt_t             conf_acc;
    } entry_t;

    entry_t tbl_q [ENTRIES];
    entry_t tbl_d [ENTRIES];

    entry_t   cur_ent;
    entry_t   new_ent;
    logic     cov_conf_up;
    logic     acc_conf_up;
    cnt_t     conf_cov_nx;
    cnt_t     conf_acc_nx;

    logic [PC_W-1:0] prog_pop, cov_pop, acc_pop, cov_hits, acc_hits;
    qbucket_e        cov_cov_q, cov_acc_q, acc_acc_q;

    assign cur_ent = tbl_q[upd_index];

    // ---- scoring ----
    dspl_popcount #(.W(LINES)) u_pc_prog (.vec(upd_pattern),                 .count(prog_pop));
    dspl_popcount #(.W(LINES)) u_pc_cov  (.vec(cur_ent.cov),                 .count(cov_pop));
    dspl_popcount #(.W(LINES)) u_pc_acc  (.vec(cur_ent.acc),                 .count(acc_pop));
    dspl_popcount #(.W(LINES)) u_pc_covh (.vec(upd_pattern & cur_ent.cov),   .count(cov_hits));
    dspl_popcount #(.W(LINES)) u_pc_acch (.vec(upd_pattern & cur_ent.acc),   .count(acc_hits));

    dspl_quartile #(.CW(PC_W)) u_q_cov_cov (.hits(cov_hits), .total(prog_pop), .bucket(cov_cov_q));
    dspl_quartile #(.CW(PC_W)) u_q_cov_acc (.hits(cov_hits), .total(cov_pop),  .bucket(cov_acc_q));
    dspl_quartile #(.CW(PC_W)) u_q_acc_acc (.hits(acc_hits), .total(acc_pop),  .bucket(acc_acc_q));

    assign cov_conf_up = (cov_cov_q < QB_HALF) || (cov_acc_q < QB_HALF);
    assign acc_conf_up = (acc_acc_q < QB_HALF);

    dspl_sat_counter #(.CW(CNT_W)) u_conf_cov (.cur(cur_ent.conf_cov), .up(cov_conf_up), .nxt(conf_cov_nx));
    dspl_sat_counter #(.CW(CNT_W)) u_conf_acc (.cur(cur_ent.conf_acc), .up(acc_conf_up), .nxt(conf_acc_nx));

    // ---- next state ----
    always_comb begin
        new_ent = cur_ent;
        if (!cur_ent.trained) begin
            new_ent.trained  = 1'b1;
            new_ent.cov      = upd_pattern;
            new_ent.acc      = upd_pattern;
            new_ent.merges   = '0;
            new_ent.conf_cov = '0;
            new_ent.conf_acc = '0;
        end else begin
            new_ent.acc      = upd_pattern & cur_ent.cov;
            new_ent.conf_cov = conf_cov_nx;
            new_ent.conf_acc = conf_acc_nx;
            if (cur_ent.merges == CNT_TOP) begin
                new_ent.cov    = upd_pattern;
                new_ent.merges = '0;
            end else begin
                new_ent.cov    = cur_ent.cov | upd_pattern;
                new_ent.merges = cur_ent.merges + 1'b1;
            end
        end

        tbl_d = tbl_q;
        if (upd_valid) tbl_d[upd_index] = new_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // ---- read port ----
    always_comb begin
        rd_valid    = tbl_q[rd_index].trained;
        rd_cov_pat  = tbl_q[rd_index].cov;
        rd_acc_pat  = tbl_q[rd_index].acc;
        rd_or_count = tbl_q[rd_index].merges;
        rd_meas_cov = tbl_q[rd_index].conf_cov;
        rd_meas_acc = tbl_q[rd_index].conf_acc;
    end

    // ---- assertions ----
    a_r3_acc_within_prog: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ((new_ent.acc & ~upd_pattern) == '0));

    a_r4_cov_holds_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cur_ent.trained && cur_ent.merges != CNT_TOP)
            |-> ((upd_pattern & ~new_ent.cov) == '0));

    a_r2_first_train_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && rd_index == upd_index && !rd_valid)
            |=> (rd_index != $past(rd_index)) || (rd_valid && rd_cov_pat == $past(upd_pattern)));

    a_r7_cov_conf_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cur_ent.trained && cur_ent.conf_cov == CNT_TOP && cov_conf_up)
            |-> (new_ent.conf_cov == CNT_TOP));

    a_r8_acc_conf_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cur_ent.trained && cur_ent.conf_acc == '0 && !acc_conf_up)
            |-> (new_ent.conf_acc == '0));
endmodule

// File: tb/dual_pattern_learner_test.sv
`timescale 1ns/1ps
module dual_pattern_learner_test;
    localparam int LINES   = 64;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = 4;
    localparam int NV      = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_index = '0;
    logic [LINES-1:0] upd_pattern = '0;
    logic [IDX_W-1:0] rd_index = '0;
    logic             rd_valid;
    logic [LINES-1:0] rd_cov_pat, rd_acc_pat;
    logic [1:0]       rd_or_count, rd_meas_cov, rd_meas_acc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dual_pattern_learner #(.LINES(LINES), .ENTRIES(ENTRIES)) uut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_index(upd_index),
        .upd_pattern(upd_pattern), .rd_index(rd_index), .rd_valid(rd_valid),
        .rd_cov_pat(rd_cov_pat), .rd_acc_pat(rd_acc_pat), .rd_or_count(rd_or_count),
        .rd_meas_cov(rd_meas_cov), .rd_meas_acc(rd_meas_acc)
    );

    // Sequence applied to entry 2: pattern, then expected cov, acc, merges, conf_cov, conf_acc
    localparam logic [63:0] VP  [NV] = '{64'h0F, 64'h3C, 64'hC0, 64'h01, 64'hF00,
                                         64'hF00, 64'hF00, 64'h300, 64'h100, 64'h8000000000000001};
    localparam logic [63:0] VC  [NV] = '{64'h0F, 64'h3F, 64'hFF, 64'hFF, 64'hF00,
                                         64'hF00, 64'hF00, 64'hF00, 64'h100, 64'h8000000000000101};
    localparam logic [63:0] VA  [NV] = '{64'h0F, 64'h0C, 64'h00, 64'h01, 64'h00,
                                         64'hF00, 64'hF00, 64'h300, 64'h100, 64'h00};
    localparam logic [1:0]  VO  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
    localparam logic [1:0]  VMC [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2};
    localparam logic [1:0]  VMA [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0, 2'd1};

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic look(input logic [IDX_W-1:0] idx);
        rd_index = idx;
        #1;
    endtask

    task automatic check_entry(input string tag, input logic v, input logic [63:0] c,
                               input logic [63:0] a, input logic [1:0] o,
                               input logic [1:0] mc, input logic [1:0] ma);
        chk({tag, " R10"}, "valid",    64'(rd_valid),    64'(v));
        chk({tag, " R4 R5"}, "cov",    rd_cov_pat,       c);
        chk({tag, " R3"}, "acc",       rd_acc_pat,       a);
        chk({tag, " R4 R5"}, "merges", 64'(rd_or_count), 64'(o));
        chk({tag, " R7 R6"}, "confcov", 64'(rd_meas_cov), 64'(mc));
        chk({tag, " R8 R6"}, "confacc", 64'(rd_meas_acc), 64'(ma));
    endtask

    task automatic update(input logic [IDX_W-1:0] idx, input logic [63:0] p);
        @(negedge clk);
        upd_valid   = 1'b1;
        upd_index   = idx;
        upd_pattern = p;
        rd_index    = idx;
        @(negedge clk);
        upd_valid   = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every entry
        for (int i = 0; i < ENTRIES; i++) begin
            look(IDX_W'(i));
            check_entry("R1", 1'b0, 64'h0, 64'h0, 2'd0, 2'd0, 2'd0);
        end

        // Vector walk on entry 2 (first vector covers R2)
        for (int v = 0; v < NV; v++) begin
            update(4'd2, VP[v]);
            look(4'd2);
            check_entry(v == 0 ? "R2" : "R9", 1'b1, VC[v], VA[v], VO[v], VMC[v], VMA[v]);
        end

        // R9: neighbour entry untouched
        look(4'd5);
        check_entry("R9", 1'b0, 64'h0, 64'h0, 2'd0, 2'd0, 2'd0);

        // R9: upd_valid low has no effect
        @(negedge clk);
        upd_index   = 4'd2;
        upd_pattern = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        look(4'd2);
        check_entry("R9", 1'b1, 64'h8000000000000101, 64'h0, 2'd1, 2'd2, 2'd1);

        // R2: first training with an empty pattern
        update(4'd7, 64'h0);
        look(4'd7);
        check_entry("R2", 1'b1, 64'h0, 64'h0, 2'd0, 2'd0, 2'd0);

        // R6: empty denominators count as lowest bucket
        update(4'd7, 64'h5);
        look(4'd7);
        check_entry("R6", 1'b1, 64'h5, 64'h0, 2'd1, 2'd1, 2'd1);

        // R1: reset mid-run clears trained entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(4'd2);
        check_entry("R1", 1'b0, 64'h0, 64'h0, 2'd0, 2'd0, 2'd0);

        finish_run();
    end
endmodule